// File: doc/BRIEF.md
# Third-Order Sinc Decimator for a One-Bit Sigma-Delta Stream

This block turns the one-bit output of a sigma-delta modulator into 16-bit unsigned words. It runs on the modulator clock. The modulator changes its data bit just after each rising clock edge and holds it until after the next rising edge, so the block registers the bit on the following rising edge. That registered bit feeds a chain of three integrators. A counter marks every 256th cycle. On that cycle, three comb stages take the difference of the integrator output against its value from the previous decimation point.

The comb result has a full scale of 2^24. The block keeps its upper sixteen significant bits and clamps the single value that does not fit, so an all-ones stream reads 65535 rather than wrapping to zero. The output code is offset binary and equals the density of ones times 65536.

Each new word comes with a strobe that is high for one clock. A settled flag stays low for the first three words after reset, while the comb history still holds values from before the stream started. A controller typically ignores words until the settled flag is high.

Top module: `sinc3_decimator`

## Requirements
- R1: The data bit present at a rising clock edge is registered on that edge and enters the filter; every clock contributes exactly one sample.
- R2: Exactly one word is produced per 256 clocks. The strobe `word_valid` is high for a single clock, and consecutive strobes are 256 clocks apart.
- R3: Once settled, a stream whose repeating pattern has a period dividing 256 gives the code density × 65536. Examples: alternating bits or eight-ones-eight-zeros give 32768, 13 ones in 16 give 53248, and 3 ones in 16 give 12288.
- R4: An all-zeros stream gives code 0. An all-ones stream gives code 65535: a comb result of 2^24 or more is clamped to 65535.
- R5: Integrators and combs are 25 bits wide and wrap modulo 2^25. Over a run of at least 24 words of all ones, every settled word stays 65535.
- R6: After reset, `word_settled` is low for words 1 to 3 and rises together with the strobe of word 4. It then stays high until the next reset.
- R7: The reset is synchronous and active high. While it is asserted and on the cycle after, `word_out` is 0 and both flags are low. It also clears all filter state, so an all-zeros stream after any earlier activity gives 0 on every word, including unsettled ones.
- R8: `word_out` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | One-bit modulator data, changing just after each rising edge |
| word_out | output | 16 | Decimated offset-binary code |
| word_valid | output | 1 | One-clock strobe marking a new `word_out` |
| word_settled | output | 1 | High once the comb history is filled (word 4 onwards) |

## Verification
Corrupted integrator or comb state persists in the comb history, so it shows up within one to three words (256 to 768 clocks) as a settled code that differs from density × 65536. That is why settled codes are compared against exact values for several patterns, including the all-ones clamp. Leftover state after reset appears on the very first word, because an all-zeros stream must then read 0 even before settling. A wrong decimation count shows up at the second strobe as a spacing other than 256 clocks, and a wrong settle count shows up at word 3 or word 4.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;
  // Default filter shape: order of the cascade, log2 of the decimation
  // ratio and the width of the delivered code.
  localparam int unsigned SINC_ORDER = 3;
  localparam int unsigned DEC_LOG2   = 8;
  localparam int unsigned CODE_W     = 16;

  // Accumulator width needed for exact modulo arithmetic.
  function automatic int unsigned acc_width(input int unsigned order,
                                            input int unsigned dlog2);
    return order * dlog2 + 1;
  endfunction
endpackage

// File: rtl/sinc3_front.sv
`timescale 1ns/1ps
// Captures the modulator bit and runs the integrator cascade.
module sinc3_front #(
  parameter int unsigned ORDER = 3,
  parameter int unsigned ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic             bit_q,
  output logic [ACC_W-1:0] acc_last
);
  logic [ORDER-1:0][ACC_W-1:0] acc;

  // The bit is valid from shortly after one rising edge until past the
  // next, so the next rising edge is the safe sampling point.
  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= bit_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else begin
      acc[0] <= acc[0] + {{(ACC_W-1){1'b0}}, bit_q};
      for (int k = 1; k < int'(ORDER); k++) begin
        acc[k] <= acc[k] + acc[k-1];
      end
    end
  end

  assign acc_last = acc[ORDER-1];
endmodule

// File: rtl/sinc3_ratio_ctr.sv
`timescale 1ns/1ps
// Free-running decimation counter; tick on the last cycle of each frame.
module sinc3_ratio_ctr #(
  parameter int unsigned DLOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [DLOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == {DLOG2{1'b1}});
endmodule

// File: rtl/sinc3_comb.sv
`timescale 1ns/1ps
// Comb cascade evaluated once per decimation tick.
module sinc3_comb #(
  parameter int unsigned ORDER = 3,
  parameter int unsigned ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] res,
  output logic             res_vld
);
  logic [ORDER-1:0][ACC_W-1:0] hist;
  logic [ORDER:0][ACC_W-1:0]   diff;

  always_comb begin
    diff[0] = acc_in;
    for (int k = 0; k < int'(ORDER); k++) begin
      diff[k+1] = diff[k] - hist[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= tick;
      if (tick) begin
        for (int k = 0; k < int'(ORDER); k++) begin
          hist[k] <= diff[k];
        end
        res <= diff[ORDER];
      end
    end
  end
endmodule

// File: rtl/sinc3_scale.sv
`timescale 1ns/1ps
// Reduces the comb result to the output code, clamps full scale and
// tracks how many words have passed since reset.
module sinc3_scale #(
  parameter int unsigned ORDER  = 3,
  parameter int unsigned ACC_W  = 25,
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  res,
  input  logic              res_vld,
  output logic [CODE_W-1:0] code,
  output logic              code_vld,
  output logic              settled
);
  localparam int unsigned SHIFT = ACC_W - 1 - CODE_W;
  localparam int unsigned CNT_W = $clog2(ORDER + 1);
  localparam logic [CNT_W-1:0] FILL = CNT_W'(ORDER);

  // Full scale is exactly 2^(ACC_W-1); anything with the top bit set
  // would wrap to zero when truncated, so clamp it.
  function automatic logic [CODE_W-1:0] to_code(input logic [ACC_W-1:0] r);
    if (r[ACC_W-1]) return {CODE_W{1'b1}};
    return r[SHIFT +: CODE_W];
  endfunction

  logic [CNT_W-1:0] n_words;

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= '0;
      code_vld <= 1'b0;
      settled  <= 1'b0;
      n_words  <= '0;
    end else begin
      code_vld <= res_vld;
      if (res_vld) begin
        code    <= to_code(res);
        settled <= (n_words == FILL);
        if (n_words != FILL) n_words <= n_words + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sinc3_decimator.sv
`timescale 1ns/1ps
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int unsigned ORDER  = SINC_ORDER,
  parameter int unsigned DLOG2  = DEC_LOG2,
  parameter int unsigned OUT_W  = CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_bit,
  output logic [OUT_W-1:0] word_out,
  output logic             word_valid,
  output logic             word_settled
);
  localparam int unsigned ACC_W = acc_width(ORDER, DLOG2);

  // Internal events named for the bound checker.
  logic             bit_q;
  logic [ACC_W-1:0] acc_top;
  logic             dec_tick;
  logic [ACC_W-1:0] comb_res;
  logic             comb_vld;

  sinc3_front #(.ORDER(ORDER), .ACC_W(ACC_W)) u_front (
    .clk(clk), .rst(rst), .bit_in(mod_bit), .bit_q(bit_q), .acc_last(acc_top)
  );

  sinc3_ratio_ctr #(.DLOG2(DLOG2)) u_ctr (
    .clk(clk), .rst(rst), .tick(dec_tick)
  );

  sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst(rst), .tick(dec_tick), .acc_in(acc_top),
    .res(comb_res), .res_vld(comb_vld)
  );

  sinc3_scale #(.ORDER(ORDER), .ACC_W(ACC_W), .CODE_W(OUT_W)) u_scale (
    .clk(clk), .rst(rst), .res(comb_res), .res_vld(comb_vld),
    .code(word_out), .code_vld(word_valid), .settled(word_settled)
  );
endmodule

// File: rtl/sinc3_decimator_chk.sv
`timescale 1ns/1ps
module sinc3_decimator_chk #(
  parameter int unsigned ACC_W = 25,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned RATIO = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_tick,
  input logic             comb_vld,
  input logic [ACC_W-1:0] comb_res,
  input logic [OUT_W-1:0] word_out,
  input logic             word_valid,
  input logic             word_settled
);
  localparam int unsigned SHIFT = ACC_W - 1 - OUT_W;

  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (word_valid) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  assert_valid_period_R2: assert property (@(posedge clk) disable iff (rst)
    (word_valid && seen) |-> (gap == RATIO - 1));
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  assert_tick_path_R2: assert property (@(posedge clk) disable iff (rst)
    dec_tick |=> comb_vld);
  assert_comb_to_word_R2: assert property (@(posedge clk) disable iff (rst)
    comb_vld |=> word_valid);
  assert_scale_R3: assert property (@(posedge clk) disable iff (rst)
    (comb_vld && !comb_res[ACC_W-1]) |=> (word_out == $past(comb_res[SHIFT +: OUT_W])));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (comb_vld && comb_res[ACC_W-1]) |=> (word_out == {OUT_W{1'b1}}));
  assert_settle_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(word_settled) |-> word_valid);
  assert_settle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    word_settled |=> word_settled);
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (word_out == '0 && !word_valid && !word_settled));
  assert_hold_word_R8: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_out));
endmodule

bind sinc3_decimator sinc3_decimator_chk #(
  .ACC_W(ACC_W), .OUT_W(OUT_W), .RATIO(1 << DLOG2)
) u_chk (
  .clk(clk), .rst(rst), .dec_tick(dec_tick), .comb_vld(comb_vld),
  .comb_res(comb_res), .word_out(word_out), .word_valid(word_valid),
  .word_settled(word_settled)
);

// File: tb/sinc3_decimator_test.sv
`timescale 1ns/1ps
module sinc3_decimator_test;
  localparam int RATIO = 256;
  localparam int WATCH_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_bit = 1'b0;
  logic [15:0] word_out;
  logic        word_valid;
  logic        word_settled;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  sinc3_decimator uut (
    .clk(clk), .rst(rst), .mod_bit(mod_bit),
    .word_out(word_out), .word_valid(word_valid), .word_settled(word_settled)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // R1: the bit is changed just after a rising edge and held through the next.
  task automatic step(input logic b);
    @(posedge clk);
    #1 mod_bit = b;
    cyc++;
    @(negedge clk);
  endtask

  // R7: reset state seen at the ports during and after reset.
  task automatic do_reset();
    @(posedge clk);
    #1 rst = 1'b1;
    mod_bit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "word_out in reset", int'(word_out), 0);
    chk("R7", "valid in reset", int'(word_valid), 0);
    chk("R7", "settled in reset", int'(word_settled), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R7", "word_out after reset", int'(word_out), 0);
    chk("R7", "settled after reset", int'(word_settled), 0);
  endtask

  // Runs one periodic pattern (period 16) from reset for nwords words.
  task automatic run_case(input string req, input logic [15:0] mask,
                          input int nwords, input int exp_code,
                          input bit all_zero_words);
    int words = 0;
    int ph = 0;
    int last_v = 0;
    int guard = 0;
    int hold_bad = 0;
    logic [15:0] prev;
    do_reset();
    prev = word_out;
    while (words < nwords && guard < nwords * RATIO + 64) begin
      step(mask[ph]);
      ph = (ph + 1) % 16;
      guard++;
      if (word_valid) begin
        words++;
        if (words > 1) chk("R2", "strobe spacing", cyc - last_v, RATIO);
        last_v = cyc;
        chk("R6", $sformatf("settled at word %0d", words),
            int'(word_settled), (words >= 4) ? 1 : 0);
        if (words >= 4)
          chk(req, $sformatf("code at word %0d mask %h", words, mask),
              int'(word_out), exp_code);
        else if (all_zero_words)
          chk("R7", $sformatf("cleared state word %0d", words), int'(word_out), 0);
        prev = word_out;
      end else begin
        if (word_out != prev) hold_bad++;
      end
    end
    chk(req, "word count reached", words, nwords);
    chk("R8", "word held between strobes", hold_bad, 0);
    // R2: one clock later the strobe is gone.
    step(mask[ph]);
    chk("R2", "strobe one cycle wide", int'(word_valid), 0);
  endtask

  initial begin
    do_reset();
    run_case("R4", 16'h0000, 6, 0, 1'b1);
    // R5: long all-ones run wraps the integrators many times.
    run_case("R4 R5", 16'hFFFF, 24, 65535, 1'b0);
    // R7: state cleared after heavy activity; zeros read 0 from word 1.
    run_case("R4 R7", 16'h0000, 6, 0, 1'b1);
    run_case("R1 R3", 16'h5555, 6, 32768, 1'b0);
    run_case("R3", 16'h00FF, 6, 32768, 1'b0);
    run_case("R3", 16'h1FFF, 6, 53248, 1'b0);
    run_case("R3", 16'h0007, 6, 12288, 1'b0);
    summary();
    $finish;
  end

  initial begin
    repeat (WATCH_CYC) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WATCH_CYC);
    summary();
    $finish;
  end
endmodule